// File: doc/BRIEF.md
# Synthesizer enable and retune sequencer

This controller walks a frequency synthesizer through its power-up, channel-hop and transmit/receive offset phases. A transceiver state request selects one of four modes (off, synthesizer-on, receive, transmit) and a channel number picks the carrier. The block drives a registered frequency word, pulses the start lines of two external calibration engines, and reports when the synthesizer may be used through a settled flag plus lock and unlock interrupt pulses. Phase lock is not modelled. Every settle is a timed wait counted in whole microseconds from a one-microsecond tick input.

The transmit carrier sits a fixed offset above the receive carrier. Entering and leaving transmit therefore retunes the synthesizer, and each direction has its own settle time. These offset shifts are kept silent: they raise no interrupts and start no calibration. A request that arrives while any wait is running is held. The block acts on it once the wait ends.

Top module: `synth_seq`

## Requirements
- R1: After reset the block is off. The frequency word is 0, and settled, tx_mode, both calibration starts and both interrupt pulses are low.
- R2: The request code is 0 for off, 1 for synthesizer-on, 2 for receive and 3 for transmit. From off, a request of 1 or 2 loads the receive word of the current channel and pulses both calibration starts for one cycle. Once EN_US ticks (default 200) have elapsed and both engines have returned done, settled rises and irq_lock pulses in the same cycle.
- R3: While off, a transmit request (3) is ignored. The word stays 0 and settled stays low.
- R4: In the settled receive or synthesizer-on mode, a change of channel pulses irq_unlock, pulses both calibration starts and loads the new receive word. Once CH_US ticks (default 11) have elapsed and both engines have returned done, settled rises and irq_lock pulses in the same cycle.
- R5: The transmit word is BASE_WORD + channel*CH_STEP. The receive word is the transmit word minus TX_OFFSET (defaults 9000, 20, 10).
- R6: A transmit request in the settled receive mode loads the transmit word, raises tx_mode and drops settled. settled rises again TXS_US ticks later (default 16).
- R7: Leaving transmit (any request other than 3) loads the receive word and drops tx_mode and settled. settled rises again RTN_US ticks later (default 32).
- R8: The transmit entry and return shifts produce no irq_lock, no irq_unlock and no calibration start.
- R9: A request that changes during a wait has no effect until that wait has completed. The word stays fixed while settled stays high.
- R10: If a calibration done arrives after the timer expires, settled waits for it.
- R11: An off request in the settled receive mode clears the word and settled on the next cycle without any interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| state_req | input | 2 | Requested transceiver mode (0 off, 1 synth-on, 2 receive, 3 transmit) |
| chan | input | CH_W | Channel number |
| cal_cf_done | input | 1 | Done pulse of the centre-frequency calibration engine |
| cal_dcu_done | input | 1 | Done pulse of the delay-cell calibration engine |
| freq_word | output | FW_W | Synthesizer frequency word |
| cal_cf_start | output | 1 | Start pulse for the centre-frequency engine |
| cal_dcu_start | output | 1 | Start pulse for the delay-cell engine |
| settled | output | 1 | Synthesizer usable in the current mode |
| tx_mode | output | 1 | Word currently holds the transmit carrier |
| irq_lock | output | 1 | Lock interrupt pulse |
| irq_unlock | output | 1 | Unlock interrupt pulse |

## Verification
Two situations are hard to reach from the ports. The first is a request that changes in the middle of the transmit-entry wait. The stimulus aligns to a tick, asks for transmit, then drops back to receive five ticks into the 16-tick wait. Both settle events are then expected at absolute tick counts. The second is calibration finishing after the timer. The bench's engine model is given a latency of 100 microseconds for one channel hop. It then confirms that settled stays low past the 11-tick timer and rises only after the late done pulses.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;
  typedef enum logic [1:0] {
    REQ_OFF = 2'd0,
    REQ_PLL = 2'd1,
    REQ_RX  = 2'd2,
    REQ_TX  = 2'd3
  } req_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ENABLE,
    ST_LOCKED,
    ST_HOP,
    ST_TX_SHIFT,
    ST_TX,
    ST_RX_SHIFT
  } seq_st_e;
endpackage

// File: rtl/synth_us_timer.sv
module synth_us_timer #(
  parameter int MAX_US = 200,
  localparam int CW = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == 0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt == 0 && !load) |=> (cnt == 0)); // R2
endmodule

// File: rtl/synth_cal_tracker.sv
module synth_cal_tracker #(
  parameter int N_ENG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic [N_ENG-1:0] done_in,
  output logic [N_ENG-1:0] start,
  output logic             all_done
);
  logic [N_ENG-1:0] ok_q;

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    always_ff @(posedge clk) begin
      if (rst) begin
        start[g] <= 1'b0;
        ok_q[g]  <= 1'b0;
      end else begin
        start[g] <= kick;
        if (kick)            ok_q[g] <= 1'b0;
        else if (done_in[g]) ok_q[g] <= 1'b1;
      end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      start[g] |=> !start[g]); // R2
  end

  assign all_done = &ok_q;
endmodule

// File: rtl/synth_freq_calc.sv
module synth_freq_calc #(
  parameter int CH_W      = 4,
  parameter int FW_W      = 16,
  parameter int BASE_WORD = 9000,
  parameter int CH_STEP   = 20,
  parameter int TX_OFFSET = 10
) (
  input  logic [CH_W-1:0] ch,
  output logic [FW_W-1:0] rx_word,
  output logic [FW_W-1:0] tx_word
);
  int tx_i;
  always_comb begin
    tx_i    = BASE_WORD + int'(ch) * CH_STEP;
    tx_word = FW_W'(tx_i);
    rx_word = FW_W'(tx_i - TX_OFFSET);
  end
endmodule

// File: rtl/synth_seq.sv
module synth_seq
  import synth_seq_pkg::*;
#(
  parameter int CH_W      = 4,
  parameter int FW_W      = 16,
  parameter int BASE_WORD = 9000,
  parameter int CH_STEP   = 20,
  parameter int TX_OFFSET = 10,
  parameter int EN_US     = 200,
  parameter int CH_US     = 11,
  parameter int TXS_US    = 16,
  parameter int RTN_US    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            us_tick,
  input  logic [1:0]      state_req,
  input  logic [CH_W-1:0] chan,
  input  logic            cal_cf_done,
  input  logic            cal_dcu_done,
  output logic [FW_W-1:0] freq_word,
  output logic            cal_cf_start,
  output logic            cal_dcu_start,
  output logic            settled,
  output logic            tx_mode,
  output logic            irq_lock,
  output logic            irq_unlock
);
  localparam int M1     = (EN_US > CH_US) ? EN_US : CH_US;
  localparam int M2     = (TXS_US > RTN_US) ? TXS_US : RTN_US;
  localparam int MAX_US = (M1 > M2) ? M1 : M2;
  localparam int CW     = $clog2(MAX_US + 1);
  localparam logic [CW-1:0] EN_V  = CW'(EN_US);
  localparam logic [CW-1:0] CH_V  = CW'(CH_US);
  localparam logic [CW-1:0] TXS_V = CW'(TXS_US);
  localparam logic [CW-1:0] RTN_V = CW'(RTN_US);

  seq_st_e         st, nxt;
  req_e            req;
  logic [CH_W-1:0] cur_ch, sel_ch;
  logic [FW_W-1:0] word_n, rx_w, tx_w;
  logic            kick, load, lock_n, unlock_n, latch_ch;
  logic [CW-1:0]   load_val;
  logic            tmr_expired, cal_all;
  logic [1:0]      cal_start;

  assign req = req_e'(state_req);

  // New channel is used when leaving off or hopping; otherwise the current one
  assign sel_ch = (st == ST_OFF || (st == ST_LOCKED && req != REQ_TX)) ? chan : cur_ch;

  synth_freq_calc #(
    .CH_W(CH_W), .FW_W(FW_W), .BASE_WORD(BASE_WORD),
    .CH_STEP(CH_STEP), .TX_OFFSET(TX_OFFSET)
  ) u_calc (
    .ch(sel_ch), .rx_word(rx_w), .tx_word(tx_w)
  );

  synth_us_timer #(.MAX_US(MAX_US)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .tick(us_tick), .expired(tmr_expired)
  );

  synth_cal_tracker #(.N_ENG(2)) u_cal (
    .clk(clk), .rst(rst), .kick(kick),
    .done_in({cal_dcu_done, cal_cf_done}),
    .start(cal_start), .all_done(cal_all)
  );

  assign cal_cf_start  = cal_start[0];
  assign cal_dcu_start = cal_start[1];

  always_comb begin
    nxt      = st;
    kick     = 1'b0;
    load     = 1'b0;
    load_val = '0;
    lock_n   = 1'b0;
    unlock_n = 1'b0;
    latch_ch = 1'b0;
    word_n   = freq_word;
    unique case (st)
      ST_OFF: begin
        if (req == REQ_PLL || req == REQ_RX) begin
          nxt = ST_ENABLE; kick = 1'b1; load = 1'b1; load_val = EN_V;
          word_n = rx_w; latch_ch = 1'b1;
        end
      end
      ST_ENABLE, ST_HOP: begin
        if (tmr_expired && cal_all) begin
          nxt = ST_LOCKED; lock_n = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (req == REQ_OFF) begin
          nxt = ST_OFF; word_n = '0;
        end else if (req == REQ_TX) begin
          nxt = ST_TX_SHIFT; load = 1'b1; load_val = TXS_V; word_n = tx_w;
        end else if (chan != cur_ch) begin
          nxt = ST_HOP; kick = 1'b1; load = 1'b1; load_val = CH_V;
          word_n = rx_w; latch_ch = 1'b1; unlock_n = 1'b1;
        end
      end
      ST_TX_SHIFT: begin
        if (tmr_expired) nxt = ST_TX;
      end
      ST_TX: begin
        if (req != REQ_TX) begin
          nxt = ST_RX_SHIFT; load = 1'b1; load_val = RTN_V; word_n = rx_w;
        end
      end
      ST_RX_SHIFT: begin
        if (tmr_expired) nxt = ST_LOCKED;
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_OFF;
      cur_ch     <= '0;
      freq_word  <= '0;
      settled    <= 1'b0;
      tx_mode    <= 1'b0;
      irq_lock   <= 1'b0;
      irq_unlock <= 1'b0;
    end else begin
      st         <= nxt;
      freq_word  <= word_n;
      settled    <= (nxt == ST_LOCKED) || (nxt == ST_TX);
      tx_mode    <= (nxt == ST_TX_SHIFT) || (nxt == ST_TX);
      irq_lock   <= lock_n;
      irq_unlock <= unlock_n;
      if (latch_ch) cur_ch <= chan;
    end
  end

  AST_SETTLE_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(settled) |-> $past(tmr_expired)); // R2
  AST_LOCK_WITH_SETTLE: assert property (@(posedge clk) disable iff (rst)
    irq_lock |-> $rose(settled)); // R4
  AST_SHIFT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_mode) |-> (!irq_lock && !irq_unlock)); // R8
  AST_CAL_ONLY_UNSETTLED: assert property (@(posedge clk) disable iff (rst)
    (cal_cf_start || cal_dcu_start) |-> (!settled && !tx_mode)); // R8
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (settled && $past(settled)) |-> $stable(freq_word)); // R9
  AST_OFF_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF) |-> (freq_word == '0 && !settled)); // R11
endmodule

// File: tb/synth_seq_tb.sv
module synth_seq_tb_top;
  localparam int CH_W = 4;
  localparam int FW_W = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            us_tick = 1'b0;
  logic [1:0]      state_req = 2'd0;
  logic [CH_W-1:0] chan = '0;
  logic            cal_cf_done = 1'b0;
  logic            cal_dcu_done = 1'b0;
  logic [FW_W-1:0] freq_word;
  logic            cal_cf_start, cal_dcu_start, settled, tx_mode, irq_lock, irq_unlock;

  synth_seq dut_i (
    .clk(clk), .rst(rst), .us_tick(us_tick), .state_req(state_req), .chan(chan),
    .cal_cf_done(cal_cf_done), .cal_dcu_done(cal_dcu_done), .freq_word(freq_word),
    .cal_cf_start(cal_cf_start), .cal_dcu_start(cal_dcu_start), .settled(settled),
    .tx_mode(tx_mode), .irq_lock(irq_lock), .irq_unlock(irq_unlock)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int    kind;   // 0 unlock, 1 lock, 2 settle
    int    tick;   // absolute tick count, -1 = any
    int    word;   // -1 = not checked
    string rq;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  int   tick_cnt = 0, phase = 0;
  int   cal_lat = 3, cf_cd = -1, dcu_cd = -1, n_cf = 0, n_dcu = 0;
  bit   prev_settled = 0, finished = 0;

  function automatic int rxw(int ch); return 9000 + ch * 20 - 10; endfunction
  function automatic int txw(int ch); return 9000 + ch * 20; endfunction

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  // microsecond tick generator
  always @(negedge clk) begin
    phase   = (phase + 1) % 4;
    us_tick = (phase == 0);
  end
  always @(posedge clk) if (us_tick) tick_cnt <= tick_cnt + 1;

  // calibration engine model
  always @(negedge clk) begin
    cal_cf_done  = (cf_cd == 0);
    cal_dcu_done = (dcu_cd == 0);
    if (cf_cd >= 0) cf_cd--;
    if (dcu_cd >= 0) dcu_cd--;
    if (!rst && cal_cf_start)  begin cf_cd = cal_lat;      n_cf++;  end
    if (!rst && cal_dcu_start) begin dcu_cd = cal_lat + 1; n_dcu++; end
  end

  task automatic take(int kind, string name);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R8", {"unexpected ", name}, tick_cnt, -1);
      return;
    end
    e = exp_q.pop_front();
    chk(e.kind == kind, e.rq, {"event kind at ", name}, kind, e.kind);
    if (e.tick >= 0) chk(tick_cnt == e.tick, e.rq, {name, " tick"}, tick_cnt, e.tick);
    if (e.word >= 0) chk(int'(freq_word) == e.word, e.rq, {name, " word"}, int'(freq_word), e.word);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_unlock) take(0, "unlock");
      if (irq_lock)   take(1, "lock");
      if (settled && !prev_settled) take(2, "settle");
      prev_settled = settled;
    end
  end

  task automatic push(int kind, int tick, int word, string rq);
    exp_t e;
    e.kind = kind; e.tick = tick; e.word = word; e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic sync(output int t0);
    @(posedge clk iff us_tick);
    @(negedge clk);
    t0 = tick_cnt;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int t0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(freq_word == 0, "R1", "word after reset", int'(freq_word), 0);
    chk(!settled && !tx_mode, "R1", "settled/tx after reset", {settled, tx_mode}, 0);
    chk(!cal_cf_start && !cal_dcu_start && !irq_lock && !irq_unlock, "R1", "pulses after reset", 1, 0);

    // R3 transmit from off ignored
    state_req = 2'd3;
    repeat (120) @(negedge clk);
    chk(freq_word == 0, "R3", "word off with tx req", int'(freq_word), 0);
    chk(!settled, "R3", "settled off with tx req", settled, 0);
    chk(n_cf == 0, "R3", "cal starts off with tx req", n_cf, 0);

    // R2 enable via synth-on, channel 3
    chan = 4'd3;
    sync(t0);
    state_req = 2'd1;
    push(1, t0 + 200, -1, "R2");
    push(2, t0 + 200, rxw(3), "R2");
    drain();
    chk(n_cf == 1 && n_dcu == 1, "R2", "cal starts on enable", n_cf + n_dcu, 2);

    // R2 receive code keeps the settled state
    state_req = 2'd2;
    repeat (8) @(negedge clk);
    chk(settled && int'(freq_word) == rxw(3), "R2", "rx code stays settled", int'(freq_word), rxw(3));

    // R4 channel hop
    sync(t0);
    chan = 4'd7;
    push(0, t0, -1, "R4");
    push(1, t0 + 11, -1, "R4");
    push(2, t0 + 11, rxw(7), "R4");
    drain();
    chk(n_cf == 2 && n_dcu == 2, "R4", "cal starts on hop", n_cf + n_dcu, 4);

    // R6 / R5 transmit entry
    sync(t0);
    state_req = 2'd3;
    push(2, t0 + 16, txw(7), "R6");
    drain();
    chk(tx_mode, "R6", "tx_mode in transmit", tx_mode, 1);
    chk(int'(freq_word) - rxw(7) == 10, "R5", "tx/rx offset", int'(freq_word) - rxw(7), 10);

    // R7 return
    sync(t0);
    state_req = 2'd2;
    push(2, t0 + 32, rxw(7), "R7");
    drain();
    chk(!tx_mode, "R7", "tx_mode after return", tx_mode, 0);
    chk(n_cf == 2 && n_dcu == 2, "R8", "no cal start on shifts", n_cf + n_dcu, 4);

    // R9 request changed during transmit-entry wait
    sync(t0);
    state_req = 2'd3;
    repeat (20) @(negedge clk);
    state_req = 2'd2;
    push(2, t0 + 16, txw(7), "R9");
    push(2, t0 + 48, rxw(7), "R9");
    drain();

    // R10 late calibration done
    cal_lat = 400;
    sync(t0);
    chan = 4'd2;
    push(0, t0, -1, "R10");
    push(1, -1, -1, "R10");
    push(2, -1, rxw(2), "R10");
    repeat (80) @(negedge clk);
    chk(!settled, "R10", "settled before late done", settled, 0);
    drain();
    chk(tick_cnt >= t0 + 100, "R10", "settle after late done", tick_cnt, t0 + 100);
    cal_lat = 3;

    // R11 off from settled receive
    state_req = 2'd0;
    @(negedge clk);
    chk(freq_word == 0 && !settled, "R11", "word/settled after off", int'(freq_word), 0);
    repeat (8) @(negedge clk);

    // R2 enable via receive code, channel 0
    chan = 4'd0;
    sync(t0);
    state_req = 2'd2;
    push(1, t0 + 200, -1, "R2");
    push(2, t0 + 200, rxw(0), "R2");
    drain();
    chk(n_cf == 4 && n_dcu == 4, "R2", "cal starts on second enable", n_cf + n_dcu, 8);

    summary();
  end
endmodule